// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt request lines from eight devices and one non-maskable event line. It tells the processor that an interrupt is waiting and which device has it. Every request line is level-sensitive and is captured in a pending register. Software sees a small register port through which it can:

- read and write an enable mask,
- read and write a priority level for each source,
- read the pending bits,
- retire a serviced request by writing its index to an acknowledge location.

In each cycle a selector looks at the pending sources that are not masked and picks the one with the highest programmed level. The result goes to a registered flag and a registered device number. The non-maskable line ignores the mask and outranks every other source. It also raises a separate indication of its own.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request line held high at a rising clock edge sets its pending bit at that edge. Pending bit i reads back as bit i of the word at address 9. Writes to address 9 leave the pending bits unchanged.
- R2: `irq_flag` is high in the cycle after the internal state holds either a pending non-maskable event or at least one pending source that is not masked. Otherwise it is low.
- R3: The mask register is at address 0, and bit i = 1 disables source i. A disabled source never raises `irq_flag` and is never reported in `irq_id`, but its pending bit stays set.
- R4: The priority level of source i is held in bits [2:0] at address 1+i. Among the enabled pending sources, `irq_id` reports the one with the numerically largest level. Equal levels go to the lower source index.
- R5: A pending non-maskable event drives `nmi_flag` and `irq_flag` high and sets `irq_id` to 8. This holds whatever the mask and the maskable sources are doing.
- R6: Writing index k to address 10 clears pending bit k, and index 8 clears the non-maskable pending state. If the request line is still high in that cycle, the bit stays set. An index above 8 clears nothing.
- R7: After reset the mask reads 0xFF, the level at address 1+i reads i, the pending bits read 0, and all outputs are 0.
- R8: `irq_id` is 0 whenever `irq_flag` is low. Address 10 and any unused address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Level-sensitive maskable request lines |
| nmi_req | input | 1 | Level-sensitive non-maskable request line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_flag | output | 1 | Interrupt pending toward the processor |
| irq_id | output | 4 | Winning device number, 8 for the non-maskable source |
| nmi_flag | output | 1 | Non-maskable event pending |

## Verification
A request presented before a rising edge is captured at that edge and shows on the outputs after the next edge. The bench therefore drives requests on a falling edge and samples two rising edges later. A mask, priority or acknowledge write takes effect at the edge that performs it, and the outputs follow one edge after that. The bench samples one edge after each write. Register reads are combinational, so the bench samples them one nanosecond after changing the address, still before the next rising edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int MASK_OFS  = 0;
  localparam int PRIO_BASE = 1;

  function automatic int prio_ofs(input int idx);
    return PRIO_BASE + idx;
  endfunction

  function automatic int pend_ofs(input int nsrc);
    return PRIO_BASE + nsrc;
  endfunction

  function automatic int ack_ofs(input int nsrc);
    return PRIO_BASE + nsrc + 1;
  endfunction
endpackage

// File: rtl/irq_reg_bank.sv
module irq_reg_bank #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [NUM_SRC-1:0]                pend_i,
  output logic [NUM_SRC-1:0]                mask_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]     prio_o,
  output logic [NUM_SRC-1:0]                clr_o,
  output logic                              nmi_clr_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  import irq_ctrl_pkg::*;

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(pend_ofs(NUM_SRC));
  localparam logic [ADDR_W-1:0] ACK_ADDR  = ADDR_W'(ack_ofs(NUM_SRC));

  logic [NUM_SRC-1:0]            mask_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] prio_q;
  logic                          ack_wr;

  assign ack_wr = we && (addr == ACK_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (we && addr == MASK_ADDR)
      mask_q <= wdata[NUM_SRC-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(prio_ofs(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[g] <= LVL_W'(g);
      else if (we && addr == MY_ADDR)
        prio_q[g] <= wdata[LVL_W-1:0];
    end

    assign clr_o[g] = ack_wr && (wdata == DATA_W'(g));
  end

  assign nmi_clr_o = ack_wr && (wdata == DATA_W'(NUM_SRC));

  always_comb begin
    rdata_o = '0;
    if (addr == MASK_ADDR)
      rdata_o = DATA_W'(mask_q);
    else if (addr == PEND_ADDR)
      rdata_o = DATA_W'(pend_i);
    for (int i = 0; i < NUM_SRC; i++)
      if (addr == ADDR_W'(prio_ofs(i)))
        rdata_o = DATA_W'(prio_q[i]);
  end

  assign mask_o = mask_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               nmi_req_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               nmi_clr_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               nmi_pend_o
);
  function automatic logic next_pend(input logic cur, input logic req, input logic clr);
    return req | (cur & ~clr);
  endfunction

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= next_pend(pend_o[g], req_i[g], clr_i[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_pend_o <= 1'b0;
    else        nmi_pend_o <= next_pend(nmi_pend_o, nmi_req_i, nmi_clr_i);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            elig_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio_i,
  output logic                          valid_o,
  output logic [IDX_W-1:0]              idx_o
);
  always_comb begin
    logic [LVL_W-1:0] best_lvl;
    best_lvl = '0;
    valid_o  = 1'b0;
    idx_o    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] > best_lvl)) begin
        valid_o  = 1'b1;
        best_lvl = prio_i[i];
        idx_o    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_flag,
  output logic [ID_W-1:0]    irq_id,
  output logic               nmi_flag
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_SRC);

  logic [NUM_SRC-1:0]            mask_w;
  logic [NUM_SRC-1:0][LVL_W-1:0] prio_w;
  logic [NUM_SRC-1:0]            clr_w;
  logic                          nmi_clr_w;
  logic [NUM_SRC-1:0]            pend_w;
  logic                          nmi_pend_w;
  logic [NUM_SRC-1:0]            elig_w;
  logic                          pick_valid_w;
  logic [IDX_W-1:0]              pick_idx_w;

  irq_reg_bank #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pend_i(pend_w), .mask_o(mask_w), .prio_o(prio_w), .clr_o(clr_w),
    .nmi_clr_o(nmi_clr_w), .rdata_o(reg_rdata)
  );

  irq_pend_latch #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req), .nmi_req_i(nmi_req),
    .clr_i(clr_w), .nmi_clr_i(nmi_clr_w), .pend_o(pend_w), .nmi_pend_o(nmi_pend_w)
  );

  assign elig_w = pend_w & ~mask_w;

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
    .elig_i(elig_w), .prio_i(prio_w), .valid_o(pick_valid_w), .idx_o(pick_idx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      irq_id   <= '0;
      nmi_flag <= 1'b0;
    end else if (nmi_pend_w) begin
      irq_flag <= 1'b1;
      irq_id   <= NMI_ID;
      nmi_flag <= 1'b1;
    end else begin
      irq_flag <= pick_valid_w;
      irq_id   <= pick_valid_w ? ID_W'(pick_idx_w) : '0;
      nmi_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] pend_q,
  input logic               nmi_pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] clr_w,
  input logic               nmi_clr_w,
  input logic               irq_flag,
  input logic [ID_W-1:0]    irq_id,
  input logic               nmi_flag
);
  assert_pend_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(req_i)) == $past(req_i));

  assert_flag_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag == $past(nmi_pend_q | (|(pend_q & ~mask_q))));

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !nmi_flag) |-> ((($past(~mask_q) >> irq_id) & NUM_SRC'(1)) != '0));

  assert_nmi_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_flag |-> (irq_flag && irq_id == ID_W'(NUM_SRC)));

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(clr_w & ~req_i)) == '0);

  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_clr_w, clr_w}));

  assert_idle_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag |-> irq_id == '0);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(irq_req), .pend_q(pend_w), .nmi_pend_q(nmi_pend_w),
  .mask_q(mask_w), .clr_w(clr_w), .nmi_clr_w(nmi_clr_w),
  .irq_flag(irq_flag), .irq_id(irq_id), .nmi_flag(nmi_flag)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       nmi_req = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_flag;
  logic [3:0] irq_id;
  logic       nmi_flag;

  int checks = 0;
  int errors = 0;
  int lv[8];
  logic [7:0] rd;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_flag(irq_flag), .irq_id(irq_id), .nmi_flag(nmi_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input int a);
    reg_addr = 4'(a);
    #1 rd = reg_rdata;
  endtask

  // winner scan from the top index down; >= lets a lower index take a tie
  function automatic int expect_id(input logic [7:0] pend, input logic [7:0] mask);
    int best = -1;
    for (int i = 7; i >= 0; i--)
      if (pend[i] && !mask[i] && (best < 0 || lv[i] >= lv[best])) best = i;
    return best;
  endfunction

  task automatic sweep_requests(input string tag);
    for (int p = 0; p < 256; p++) begin
      int e;
      irq_req = 8'(p);
      tick(2);
      e = expect_id(8'(p), 8'h00);
      chk({tag, " flag R2"}, int'(irq_flag), (p != 0) ? 1 : 0);
      chk({tag, " id R4"}, int'(irq_id), (e < 0) ? 0 : e);
      rdreg(9);
      chk("pending readback R1", int'(rd), p);
      irq_req = '0;
      for (int i = 0; i < 8; i++) if (p[i]) wr(10, i);
      tick(1);
      chk("cleared by ack R6", int'(irq_flag), 0);
      chk("idle id R8", int'(irq_id), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) lv[i] = i;
    tick(2);
    // R7 reset state
    chk("reset flag R7", int'(irq_flag), 0);
    chk("reset id R7", int'(irq_id), 0);
    chk("reset nmi R7", int'(nmi_flag), 0);
    rdreg(0);
    chk("reset mask R7", int'(rd), 255);
    rdreg(9);
    chk("reset pending R7", int'(rd), 0);
    for (int i = 0; i < 8; i++) begin
      rdreg(1 + i);
      chk("reset level R7", int'(rd), i);
    end
    rst_n = 1'b1;
    tick(1);
    // masked after reset: pending but no flag
    irq_req = 8'h24;
    tick(2);
    chk("masked source silent R3", int'(irq_flag), 0);
    rdreg(9);
    chk("masked still pending R3", int'(rd), 8'h24);
    irq_req = '0;
    wr(10, 2); wr(10, 5);
    wr(0, 0);
    tick(1);
    sweep_requests("default levels");

    // levels with ties: 0,3,2,1,0,3,2,1
    for (int i = 0; i < 8; i++) begin
      lv[i] = (i * 3) % 4;
      wr(1 + i, lv[i]);
      rdreg(1 + i);
      chk("level readback R4", int'(rd), lv[i]);
    end
    sweep_requests("tied levels");

    // mask sweep with all sources held
    irq_req = 8'hFF;
    tick(1);
    for (int m = 0; m < 256; m++) begin
      int e;
      wr(0, m);
      tick(1);
      e = expect_id(8'hFF, 8'(m));
      chk("mask flag R3", int'(irq_flag), (m != 255) ? 1 : 0);
      chk("mask id R3", int'(irq_id), (e < 0) ? 0 : e);
    end
    rdreg(9);
    chk("mask keeps pending R3", int'(rd), 255);
    wr(9, 0);
    rdreg(9);
    chk("pending not writable R1", int'(rd), 255);
    rdreg(10);
    chk("ack reads zero R8", int'(rd), 0);
    rdreg(15);
    chk("unused reads zero R8", int'(rd), 0);
    irq_req = '0;
    for (int i = 0; i < 8; i++) wr(10, i);
    tick(1);

    // R5 non-maskable path
    wr(0, 255);
    irq_req = 8'h80;
    nmi_req = 1'b1;
    tick(2);
    chk("nmi flag R5", int'(nmi_flag), 1);
    chk("nmi irq R5", int'(irq_flag), 1);
    chk("nmi id R5", int'(irq_id), 8);
    wr(0, 0);
    tick(1);
    chk("nmi outranks R5", int'(irq_id), 8);
    nmi_req = 1'b0;
    wr(10, 8);
    tick(1);
    chk("nmi cleared R6", int'(nmi_flag), 0);
    chk("next winner R4", int'(irq_id), 7);
    wr(10, 7);
    tick(1);
    chk("held request survives ack R6", int'(irq_id), 7);
    irq_req = '0;
    wr(10, 7);
    tick(1);
    chk("ack clears R6", int'(irq_flag), 0);
    irq_req = 8'h01;
    tick(1);
    irq_req = '0;
    wr(10, 12);
    tick(1);
    chk("ack out of range R6", int'(irq_flag), 1);
    rdreg(9);
    chk("out of range keeps pending R6", int'(rd), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule